// File: doc/BRIEF.md
# Serial Port Peripheral on an APB Slave

This block is a byte-wide asynchronous serial port that software drives through four 32-bit registers on an APB slave port. Writes to the data register queue characters in a transmit FIFO. A transmit engine sends each character as one start bit, eight data bits (least significant bit first), an optional parity bit and one stop bit. A receive engine recovers characters from the serial input and queues them in a receive FIFO, which software drains by reading the data register.

One programmable scaler sets the bit timing. It produces a tick every scaler+1 clocks, and every bit lasts eight ticks. Sticky error flags report break, overrun, parity and framing conditions, and a write to the status register clears them. The transmit FIFO fill level can be read at any time from the status word. Hardware flow control works on an active-low clear-to-send input and an active-low request-to-send output. An internal loopback path feeds the transmit line straight into the receiver. A single level interrupt combines the receive and transmit events.

Top module: `apb_serial_port`

## Requirements
- R1: The register window is 256 bytes. The word offsets are 0x0 data, 0x4 status, 0x8 control and 0xC scaler, and any other offset reads 0. After reset the status word reads 0x00000006, control and scaler read 0, txd is 1 and irq is 0.
- R2: The control bits are: bit7 loopback, bit6 flow control, bit5 parity enable, bit4 odd parity (0 selects even), bit3 transmit interrupt enable, bit2 receive interrupt enable, bit1 transmitter enable, bit0 receiver enable. Control reads back as written.
- R3: Status bits 25:20 give the number of characters in the transmit FIFO. Each write to data adds one. A write made while the FIFO holds DEPTH characters is dropped.
- R4: Each frame on txd is a 0 start bit, then data bits 0 to 7, then a parity bit if enabled (even: XOR of the data; odd: its inverse), then a 1 stop bit. Every bit lasts 8*(scaler+1) clocks.
- R5: Received characters are read from data bits 7:0 in arrival order, and each read removes one. Status bit0 is 1 while the receive FIFO is not empty. Status bit1 is 1 while no frame is being shifted out, and status bit2 is 1 while the transmit FIFO is empty. With loopback set, txd drives the receiver.
- R6: While the transmitter enable is 0, queued characters stay in the FIFO and txd stays 1.
- R7: A frame received as all zeros, stop bit included, sets status bit3 (break). It does not set bit5 or bit6 and stores no character.
- R8: A 0 stop bit on a frame that is not a break sets status bit6. A parity mismatch sets bit5. The character is still stored. Any write to status clears bits 3 to 6.
- R9: With flow control set, no new frame starts while cts_n is 1, and rts_n is 1 while the receive FIFO is full. With flow control clear, rts_n is 0.
- R10: A character that completes while the receive FIFO is full sets status bit4 (overrun). That character is dropped and the stored characters are kept.
- R11: irq = (bit2 of control AND status bit0) OR (bit3 of control AND status bit2).
- R12: While the receiver enable is 0, incoming frames are ignored and status bit0 stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 8 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| rxd | input | 1 | Serial input |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output |
| rts_n | output | 1 | Request to send, active low |
| irq | output | 1 | Interrupt, active high |

## Verification
The assertions hold the following on every cycle:
- Each accepted data write raises the transmit fill count by exactly one, and the count never exceeds DEPTH.
- An idle transmitter stays idle with txd high while it is disabled or while clear-to-send is withheld under flow control.
- A status write with no frame completing leaves all sticky flags clear.
- A break is never reported together with framing or parity errors.

The bench scenarios show the rest:
- The bit-level frame contents and timing, for both parity senses.
- Arrival order through the FIFOs, and the dropping of writes to a full transmit FIFO.
- Each error flag, produced by deliberately malformed frames driven on rxd.
- Overrun, rts_n, the interrupt terms, and the ignoring of frames while the receiver is disabled.

// File: rtl/apb_serial_port_pkg.sv
package apb_serial_port_pkg;

    // Control register, bit7 down to bit0
    typedef struct packed {
        logic lb;
        logic flow;
        logic par_en;
        logic par_odd;
        logic tie;
        logic rie;
        logic tx_en;
        logic rx_en;
    } ctrl_t;

    typedef struct packed {
        logic frm;
        logic par;
        logic ovr;
        logic brk;
    } errs_t;

    typedef enum logic [1:0] {
        RX_IDLE    = 2'd0,
        RX_RUN     = 2'd1,
        RX_WAIT_HI = 2'd2
    } rx_state_e;

    // Word indices of the register window
    localparam logic [5:0] OFS_DATA = 6'd0;
    localparam logic [5:0] OFS_STAT = 6'd1;
    localparam logic [5:0] OFS_CTRL = 6'd2;
    localparam logic [5:0] OFS_SCAL = 6'd3;

endpackage

// File: rtl/serial_fifo.sv
module serial_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_s_t;

    fifo_s_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign do_push = push && (s_q.cnt != CW'(DEPTH));
    assign do_pop  = pop && (s_q.cnt != '0);

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wr = (s_q.wr == PW'(DEPTH-1)) ? '0 : s_q.wr + 1'b1;
        if (do_pop)  s_d.rd = (s_q.rd == PW'(DEPTH-1)) ? '0 : s_q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wr] <= din;
    end

    assign dout  = mem[s_q.rd];
    assign count = s_q.cnt;
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);
endmodule

// File: rtl/serial_tx.sv
module serial_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       tx_en,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       flow_en,
    input  logic       cts_n,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       fifo_pop,
    output logic       txd,
    output logic       idle
);
    typedef struct packed {
        logic        busy;
        logic [10:0] sh;
        logic [2:0]  sub;
        logic [3:0]  nleft;
    } tx_s_t;

    tx_s_t s_d, s_q;
    logic  start, pbit;

    assign pbit  = (^fifo_data) ^ par_odd;
    assign start = !s_q.busy && tick && tx_en && !fifo_empty && !(flow_en && cts_n);

    always_comb begin
        s_d      = s_q;
        fifo_pop = 1'b0;
        if (start) begin
            fifo_pop = 1'b1;
            s_d.busy  = 1'b1;
            s_d.sub   = '0;
            s_d.sh    = {1'b1, (par_en ? pbit : 1'b1), fifo_data, 1'b0};
            s_d.nleft = par_en ? 4'd10 : 4'd9;
        end else if (s_q.busy && tick) begin
            s_d.sub = s_q.sub + 1'b1;
            if (s_q.sub == 3'd7) begin
                if (s_q.nleft == '0) begin
                    s_d.busy = 1'b0;
                end else begin
                    s_d.sh    = {1'b1, s_q.sh[10:1]};
                    s_d.nleft = s_q.nleft - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{busy: 1'b0, sh: '1, sub: '0, nleft: '0};
        else        s_q <= s_d;
    end

    assign txd  = s_q.busy ? s_q.sh[0] : 1'b1;
    assign idle = !s_q.busy;
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import apb_serial_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_en,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rx_in,
    output logic       done,
    output logic [7:0] data,
    output logic       brk,
    output logic       fe,
    output logic       pe
);
    typedef struct packed {
        rx_state_e   st;
        logic [2:0]  sub;
        logic [3:0]  idx;
        logic [7:0]  data;
        logic        pbit;
        logic        done;
        logic        brk;
        logic        fe;
        logic        pe;
    } rx_s_t;

    rx_s_t s_d, s_q;
    logic  brk_v;
    logic [3:0] last_idx;

    assign last_idx = par_en ? 4'd10 : 4'd9;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        brk_v    = 1'b0;
        case (s_q.st)
            RX_IDLE: begin
                if (tick && rx_en && !rx_in) begin
                    s_d.st  = RX_RUN;
                    s_d.sub = '0;
                    s_d.idx = '0;
                end
            end
            RX_RUN: begin
                if (tick) begin
                    s_d.sub = s_q.sub + 1'b1;
                    // sample on the 4th tick of each bit
                    if (s_q.sub == 3'd3) begin
                        s_d.idx = s_q.idx + 1'b1;
                        if (s_q.idx == 4'd0) begin
                            if (rx_in) s_d.st = RX_IDLE;
                        end else if (s_q.idx <= 4'd8) begin
                            s_d.data = {rx_in, s_q.data[7:1]};
                        end else if (s_q.idx == last_idx) begin
                            brk_v    = (s_q.data == 8'h00) && !rx_in && !(par_en && s_q.pbit);
                            s_d.done = 1'b1;
                            s_d.brk  = brk_v;
                            s_d.fe   = !rx_in && !brk_v;
                            s_d.pe   = par_en && !brk_v && (s_q.pbit != ((^s_q.data) ^ par_odd));
                            s_d.st   = RX_WAIT_HI;
                        end else begin
                            s_d.pbit = rx_in;
                        end
                    end
                end
            end
            RX_WAIT_HI: begin
                if (rx_in) s_d.st = RX_IDLE;
            end
            default: s_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: RX_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign done = s_q.done;
    assign data = s_q.data;
    assign brk  = s_q.brk;
    assign fe   = s_q.fe;
    assign pe   = s_q.pe;
endmodule

// File: rtl/apb_serial_port.sv
module apb_serial_port
    import apb_serial_port_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int SCALER_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [7:0]  paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    input  logic        rxd,
    input  logic        cts_n,
    output logic        txd,
    output logic        rts_n,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        ctrl_t               ctrl;
        logic [SCALER_W-1:0] scal;
        logic [SCALER_W-1:0] cnt;
        errs_t               errs;
        logic [1:0]          sync;
    } regs_t;

    regs_t r_d, r_q;

    logic [5:0]    word;
    logic          aligned, wr_acc, rd_acc, tick;
    logic          tx_push, rx_pop, stat_wr;
    logic          tx_pop, tx_idle, tx_full, tx_empty;
    logic [7:0]    tx_dout, rx_dout, rx_data;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          rx_full, rx_empty, rx_push, rx_in;
    logic          rx_done, rx_brk, rx_fe, rx_pe;
    logic [31:0]   status;
    logic          unused_wdata;

    assign unused_wdata = ^{pwdata[31:SCALER_W], rx_cnt};
    assign word    = paddr[7:2];
    assign aligned = (paddr[1:0] == 2'b00);
    assign wr_acc  = psel && penable && pwrite && aligned;
    assign rd_acc  = psel && penable && !pwrite && aligned;
    assign tick    = (r_q.cnt == '0);
    assign tx_push = wr_acc && (word == OFS_DATA);
    assign stat_wr = wr_acc && (word == OFS_STAT);
    assign rx_pop  = rd_acc && (word == OFS_DATA);
    assign rx_push = rx_done && !rx_brk;
    assign rx_in   = r_q.ctrl.lb ? txd : r_q.sync[1];

    serial_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(pwdata[7:0]),
        .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    serial_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_data),
        .pop(rx_pop), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    serial_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(r_q.ctrl.tx_en),
        .par_en(r_q.ctrl.par_en), .par_odd(r_q.ctrl.par_odd), .flow_en(r_q.ctrl.flow),
        .cts_n(cts_n), .fifo_empty(tx_empty), .fifo_data(tx_dout),
        .fifo_pop(tx_pop), .txd(txd), .idle(tx_idle)
    );

    serial_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(r_q.ctrl.rx_en),
        .par_en(r_q.ctrl.par_en), .par_odd(r_q.ctrl.par_odd), .rx_in(rx_in),
        .done(rx_done), .data(rx_data), .brk(rx_brk), .fe(rx_fe), .pe(rx_pe)
    );

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[0], rxd};
        r_d.cnt  = tick ? r_q.scal : r_q.cnt - 1'b1;
        if (wr_acc && (word == OFS_CTRL)) r_d.ctrl = ctrl_t'(pwdata[7:0]);
        if (wr_acc && (word == OFS_SCAL)) r_d.scal = pwdata[SCALER_W-1:0];
        if (stat_wr) r_d.errs = '0;
        if (rx_done) begin
            if (rx_brk)             r_d.errs.brk = 1'b1;
            if (rx_fe)              r_d.errs.frm = 1'b1;
            if (rx_pe)              r_d.errs.par = 1'b1;
            if (rx_push && rx_full) r_d.errs.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ctrl: '0, scal: '0, cnt: '0, errs: '0, sync: 2'b11};
        else        r_q <= r_d;
    end

    assign status = {6'b0, 6'(tx_cnt), 13'b0,
                     r_q.errs.frm, r_q.errs.par, r_q.errs.ovr, r_q.errs.brk,
                     tx_empty, tx_idle, !rx_empty};

    always_comb begin
        prdata = '0;
        if (aligned) begin
            case (word)
                OFS_DATA: prdata = rx_empty ? 32'h0 : {24'h0, rx_dout};
                OFS_STAT: prdata = status;
                OFS_CTRL: prdata = {24'h0, r_q.ctrl};
                OFS_SCAL: prdata = 32'(r_q.scal);
                default:  prdata = '0;
            endcase
        end
    end

    assign rts_n = r_q.ctrl.flow && rx_full;
    assign irq   = (r_q.ctrl.rie && !rx_empty) || (r_q.ctrl.tie && tx_empty);
endmodule

// File: rtl/apb_serial_port_chk.sv
module apb_serial_port_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tx_push,
    input logic                       tx_full,
    input logic                       tx_pop,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic                       tx_idle,
    input logic                       tx_en,
    input logic                       flow,
    input logic                       cts_n,
    input logic                       txd,
    input logic                       stat_wr,
    input logic                       rx_done,
    input logic [3:0]                 errs,
    input logic                       rx_brk,
    input logic                       rx_fe,
    input logic                       rx_pe
);
    localparam int CW = $clog2(DEPTH+1);

    // R3: an accepted write raises the fill level by one
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push && !tx_full && !tx_pop |=> tx_cnt == $past(tx_cnt) + 1'b1);

    // R3: fill level never passes the depth
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH));

    // R6: a disabled idle transmitter keeps the line high
    p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle && !tx_en |=> txd);

    // R9: no new frame while clear-to-send is withheld
    p_cts_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle && flow && cts_n |=> tx_idle);

    // R8: a status write with no frame completing clears every flag
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && !rx_done |=> errs == 4'b0);

    // R7: break is reported alone
    p_break_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && rx_brk |-> !rx_fe && !rx_pe);
endmodule

bind apb_serial_port apb_serial_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_full(tx_full), .tx_pop(tx_pop),
    .tx_cnt(tx_cnt), .tx_idle(tx_idle), .tx_en(r_q.ctrl.tx_en), .flow(r_q.ctrl.flow),
    .cts_n(cts_n), .txd(txd), .stat_wr(stat_wr), .rx_done(rx_done), .errs(r_q.errs),
    .rx_brk(rx_brk), .rx_fe(rx_fe), .rx_pe(rx_pe)
);

// File: tb/apb_serial_port_tb.sv
module apb_serial_port_tb;
    localparam int DEPTH = 8;
    localparam int S     = 3;
    localparam int BITC  = 8 * (S + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        rxd = 1'b1, cts_n = 1'b0;
    logic        txd, rts_n, irq;

    int n_chk = 0;
    int n_err = 0;
    logic [9:0] exp_q[$];
    logic par_en_m = 1'b0, par_odd_m = 1'b0;

    always #10 clk = ~clk;

    apb_serial_port #(.DEPTH(DEPTH), .SCALER_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rxd(rxd), .cts_n(cts_n),
        .txd(txd), .rts_n(rts_n), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic tx_send(input logic [7:0] d);
        exp_q.push_back({par_en_m, par_odd_m, d});
        apb_wr(8'h00, {24'h0, d});
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_rx(input logic [7:0] d, input logic pen, input logic pb, input logic stop);
        @(negedge clk);
        rxd = 1'b0; wait_clk(BITC);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_clk(BITC); end
        if (pen) begin rxd = pb; wait_clk(BITC); end
        rxd = stop; wait_clk(BITC);
        rxd = 1'b1; wait_clk(2 * BITC);
    endtask

    // Monitor: decodes txd and compares against the scoreboard queue (R4)
    logic [9:0] m_e;
    logic [7:0] m_d;
    logic       m_st, m_pb, m_sb;
    initial begin
        forever begin
            @(negedge txd);
            if (exp_q.size() == 0) begin
                check("R4 unexpected frame", 32'd1, 32'd0);
                m_e = '0;
            end else begin
                m_e = exp_q.pop_front();
            end
            wait_clk(BITC / 2);
            m_st = txd;
            for (int i = 0; i < 8; i++) begin wait_clk(BITC); m_d[i] = txd; end
            if (m_e[9]) begin wait_clk(BITC); m_pb = txd; end
            wait_clk(BITC);
            m_sb = txd;
            check("R4 start bit", {31'b0, m_st}, 32'd0);
            check("R4 data bits", {24'b0, m_d}, {24'b0, m_e[7:0]});
            if (m_e[9]) check("R4 parity bit", {31'b0, m_pb}, {31'b0, (^m_e[7:0]) ^ m_e[8]});
            check("R4 stop bit", {31'b0, m_sb}, 32'd1);
        end
    end

    task automatic run_all();
        logic [31:0] v;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);

        // R1 reset state and map
        apb_rd(8'h04, v); check("R1 status after reset", v, 32'h6);
        apb_rd(8'h08, v); check("R1 ctrl after reset", v, 32'h0);
        apb_rd(8'h10, v); check("R1 unmapped offset", v, 32'h0);
        check("R1 txd idle", {31'b0, txd}, 32'd1);
        check("R1 irq low", {31'b0, irq}, 32'd0);
        check("R9 rts_n low without flow", {31'b0, rts_n}, 32'd0);
        apb_wr(8'h0C, S);
        apb_rd(8'h0C, v); check("R1 scaler readback", v, S);

        // R6 / R3: queued with transmitter off
        apb_wr(8'h08, 32'h00);
        tx_send(8'h11); tx_send(8'h22); tx_send(8'h33);
        apb_rd(8'h04, v); check("R3 fill level 3", (v >> 20) & 32'h3F, 32'd3);
        wait_clk(400);
        check("R6 txd stays high", {31'b0, txd}, 32'd1);
        apb_rd(8'h04, v); check("R6 chars kept", (v >> 20) & 32'h3F, 32'd3);

        // R4 / R5: loopback transfer
        apb_wr(8'h08, 32'h83);
        apb_rd(8'h08, v); check("R2 ctrl readback", v, 32'h83);
        wait_clk(1200);
        apb_rd(8'h04, v); check("R5 status after loopback", v, 32'h7);
        apb_rd(8'h00, v); check("R5 first char", v, 32'h11);
        apb_rd(8'h00, v); check("R5 second char", v, 32'h22);
        apb_rd(8'h00, v); check("R5 third char", v, 32'h33);
        apb_rd(8'h04, v); check("R5 data ready cleared", v & 32'h1, 32'h0);

        // R4 even parity then odd parity
        par_en_m = 1'b1; par_odd_m = 1'b0;
        apb_wr(8'h08, 32'hA3);
        tx_send(8'hA5);
        wait_clk(500);
        apb_rd(8'h00, v); check("R4 even parity char", v, 32'hA5);
        apb_rd(8'h04, v); check("R8 no parity error even", v & 32'h60, 32'h0);
        par_odd_m = 1'b1;
        apb_wr(8'h08, 32'hB3);
        tx_send(8'h03);
        wait_clk(500);
        apb_rd(8'h00, v); check("R4 odd parity char", v, 32'h03);
        apb_rd(8'h04, v); check("R8 no parity error odd", v & 32'h60, 32'h0);
        par_en_m = 1'b0; par_odd_m = 1'b0;

        // R11 interrupt terms
        apb_wr(8'h08, 32'h87);
        tx_send(8'h5A);
        wait_clk(500);
        check("R11 irq on receive", {31'b0, irq}, 32'd1);
        apb_rd(8'h00, v); check("R5 irq test char", v, 32'h5A);
        check("R11 irq drops after read", {31'b0, irq}, 32'd0);
        apb_wr(8'h08, 32'h8B);
        check("R11 irq on tx empty", {31'b0, irq}, 32'd1);
        apb_wr(8'h08, 32'h08);
        tx_send(8'h44);
        check("R11 irq low with tx queued", {31'b0, irq}, 32'd0);
        apb_wr(8'h08, 32'h83);
        wait_clk(500);
        apb_rd(8'h00, v); check("R5 queued char", v, 32'h44);

        // R12 receiver disabled
        apb_wr(8'h08, 32'h82);
        tx_send(8'h66);
        wait_clk(500);
        apb_rd(8'h04, v); check("R12 frame ignored", v, 32'h6);

        // R7 break on rxd
        apb_wr(8'h08, 32'h01);
        @(negedge clk); rxd = 1'b0; wait_clk(10 * BITC); rxd = 1'b1; wait_clk(2 * BITC);
        apb_rd(8'h04, v); check("R7 break flag alone", v & 32'h7F, 32'h0E);
        apb_wr(8'h04, 32'h0);
        apb_rd(8'h04, v); check("R8 break cleared", v & 32'h7F, 32'h06);

        // R8 framing error
        drive_rx(8'h55, 1'b0, 1'b0, 1'b0);
        apb_rd(8'h04, v); check("R8 framing flag", v & 32'h7F, 32'h47);
        apb_rd(8'h00, v); check("R8 framing char kept", v, 32'h55);
        apb_wr(8'h04, 32'h0);

        // R8 parity error
        apb_wr(8'h08, 32'h21);
        drive_rx(8'h0F, 1'b1, 1'b1, 1'b1);
        apb_rd(8'h04, v); check("R8 parity flag", v & 32'h7F, 32'h27);
        apb_rd(8'h00, v); check("R8 parity char kept", v, 32'h0F);
        apb_wr(8'h04, 32'h0);
        apb_rd(8'h04, v); check("R8 flags cleared", v & 32'h7F, 32'h06);

        // R10 / R9 overrun and rts_n
        apb_wr(8'h08, 32'hC3);
        for (int i = 0; i < DEPTH; i++) tx_send(8'h80 + 8'(i));
        wait_clk(3000);
        check("R9 rts_n high when rx full", {31'b0, rts_n}, 32'd1);
        apb_rd(8'h04, v); check("R10 no overrun yet", v & 32'h10, 32'h0);
        tx_send(8'hF0);
        wait_clk(500);
        apb_rd(8'h04, v); check("R10 overrun flag", v & 32'h7F, 32'h17);
        for (int i = 0; i < DEPTH; i++) begin
            apb_rd(8'h00, v); check("R10 stored char kept", v, 32'h80 + i);
            if (i == 0) check("R9 rts_n low after read", {31'b0, rts_n}, 32'd0);
        end
        apb_wr(8'h04, 32'h0);

        // R9 clear-to-send hold
        cts_n = 1'b1;
        tx_send(8'h3C);
        wait_clk(600);
        check("R9 txd held by cts_n", {31'b0, txd}, 32'd1);
        apb_rd(8'h04, v); check("R9 char waits", (v >> 20) & 32'h3F, 32'd1);
        cts_n = 1'b0;
        wait_clk(500);
        apb_rd(8'h00, v); check("R9 char sent after cts", v, 32'h3C);

        // R3 writes to a full transmit FIFO are dropped
        apb_wr(8'h08, 32'h00);
        for (int i = 0; i < DEPTH + 2; i++) begin
            if (i < DEPTH) tx_send(8'h90 + 8'(i));
            else apb_wr(8'h00, 32'h90 + i);
        end
        apb_rd(8'h04, v); check("R3 fill level capped", (v >> 20) & 32'h3F, DEPTH);
        apb_wr(8'h08, 32'h83);
        wait_clk(2900);
        for (int i = 0; i < DEPTH; i++) begin
            apb_rd(8'h00, v); check("R3 accepted char order", v, 32'h90 + i);
        end
        apb_rd(8'h04, v); check("R3 extra writes dropped", v, 32'h6);
        check("R4 all frames seen", exp_q.size(), 32'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule